// File: doc/BRIEF.md
# ADC Power and Conversion Sequencer

This block is the digital controller that brings an analog-to-digital converter out of its powered-down state, holds it through a settling period, lets software launch and abort conversions, and takes it back down. Software works through four one-shot request bits in a control register: power on, power off, begin conversion and abort conversion. Each bit reads back as 1 while its request is in flight. The block clears the bit itself once the matching state has been reached. A sticky ready flag, optionally routed to an interrupt line, reports every completed power-up.

The converter is modelled by two pins. The block drives `pwr_up` while the converter must be powered and `conv_req` while a conversion is wanted. The converter answers with `conv_done`, or with `stop_ack` after an abort. In the automatic power mode, software never touches the power bits. A conversion request powers the converter, waits out the settling time, converts and powers down again. The ready flag still rises on every power-up.

All pins are plain control and status lines. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, all control bits, the ready flag and all configuration bits read 0, and `pwr_up`, `conv_req` and `rdy_irq` are low.
- R2: Writing 1 to control bit 0 (power on) sets that bit and raises `pwr_up` one cycle after the write edge. The ready flag (status bit 0) is set `STARTUP_CYC` cycles after that, and not earlier.
- R3: The ready flag stays set until software writes 1 to status bit 0. Writing 0 leaves it unchanged. `rdy_irq` equals the flag ANDed with configuration bit 0.
- R4: Writing 1 to control bit 2 (begin conversion) in the ready state sets that bit, and `conv_req` rises one cycle later. When `conv_done` is sampled high, bit 2 clears, `conv_req` falls and the block is ready again.
- R5: Writing 1 to control bit 3 (abort) is accepted only while a conversion runs, and `conv_req` drops at once. Bits 3 and 2 both stay 1 until `conv_done` or `stop_ack` is sampled, then clear together.
- R6: Writing 1 to control bit 1 (power off) is accepted only while power-on is set and bit 2 is 0. Bit 1 reads 1 for one cycle, then bits 1 and 0 clear together and `pwr_up` falls.
- R7: A power-on write while power-off is pending has no effect. A begin-conversion write outside the ready state also has no effect.
- R8: With configuration bit 1 (automatic power) set, power-on writes are ignored. A begin-conversion write while powered down raises `pwr_up` one cycle later. After `STARTUP_CYC` further cycles it sets the ready flag and raises `conv_req`. Completion of the conversion drops `pwr_up`.
- R9: Configuration bit 1 changes only while the converter is powered down, with power-on and begin-conversion both 0. Otherwise the write of that bit is ignored.
- R10: Reads are combinational: address 0 gives the control bits, address 1 the status flag, address 2 the configuration, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| conv_done | input | 1 | Converter reports end of conversion |
| stop_ack | input | 1 | Converter acknowledges an abort |
| pwr_up | output | 1 | Converter power enable |
| conv_req | output | 1 | Conversion request to the converter |
| rdy_irq | output | 1 | Ready interrupt |

## Verification
The hardest case to reach from the pins is the single cycle in which power-off is pending. A power-on write can only collide with it if it lands on the very next edge, so the bench issues the two writes back to back with no idle cycle between them. The abort path ending through `stop_ack` rather than `conv_done` needs a conversion held open. The stimulus table therefore keeps `conv_done` low, places the abort and then the acknowledge on separate steps, and checks that `conv_req` stays low in between.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF     = 2'd0,
    SEQ_SETTLE  = 2'd1,
    SEQ_READY   = 2'd2,
    SEQ_CONVERT = 2'd3
  } seq_state_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CFG  = 2'd2;

  localparam int B_PON   = 0;
  localparam int B_POFF  = 1;
  localparam int B_BEGIN = 2;
  localparam int B_ABORT = 3;
  localparam int B_IE    = 0;
  localparam int B_AUTO  = 1;
endpackage

// File: rtl/adc_seq_settle_timer.sv
module adc_seq_settle_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!done)    cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == CW'(CYC - 1));

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= CW'(CYC - 1))); // R2
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_mode,
  input  logic       pon,
  input  logic       poff,
  input  logic       begin_q,
  input  logic       abort_q,
  input  logic       conv_done,
  input  logic       stop_ack,
  input  logic       settle_done,
  output seq_state_t state,
  output logic       settle_run,
  output logic       rdy_evt,
  output logic       off_evt,
  output logic       conv_end
);
  seq_state_t nxt;

  always_comb begin
    nxt      = state;
    rdy_evt  = 1'b0;
    off_evt  = 1'b0;
    conv_end = 1'b0;
    case (state)
      SEQ_OFF: begin
        if (auto_mode ? begin_q : (pon && !poff)) nxt = SEQ_SETTLE;
      end
      SEQ_SETTLE: begin
        if (!auto_mode && poff) begin
          nxt     = SEQ_OFF;
          off_evt = 1'b1;
        end else if (settle_done) begin
          nxt     = auto_mode ? SEQ_CONVERT : SEQ_READY;
          rdy_evt = 1'b1;
        end
      end
      SEQ_READY: begin
        if (poff) begin
          nxt     = SEQ_OFF;
          off_evt = 1'b1;
        end else if (begin_q) begin
          nxt = SEQ_CONVERT;
        end
      end
      SEQ_CONVERT: begin
        if (conv_done || (abort_q && stop_ack)) begin
          nxt      = auto_mode ? SEQ_OFF : SEQ_READY;
          conv_end = 1'b1;
        end
      end
      default: nxt = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_OFF;
    else        state <= nxt;
  end

  assign settle_run = (state == SEQ_SETTLE);

  AST_AUTO_SKIPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode |-> (state != SEQ_READY)); // R8
  AST_CONV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_CONVERT && !conv_done && !stop_ack) |=> (state == SEQ_CONVERT)); // R4
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  seq_state_t state,
  input  logic       rdy_evt,
  input  logic       off_evt,
  input  logic       conv_end,
  output logic       pon,
  output logic       poff,
  output logic       begin_q,
  output logic       abort_q,
  output logic       rdy_flag,
  output logic       irq_en,
  output logic       auto_mode
);
  logic wr_ctrl, wr_stat, wr_cfg;
  logic acc_pon, acc_poff, acc_begin, acc_abort, auto_unlocked;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);

  assign acc_pon   = wr_ctrl && reg_wdata[B_PON] && !auto_mode && !poff;
  assign acc_poff  = wr_ctrl && reg_wdata[B_POFF] && !auto_mode && pon && !begin_q;
  assign acc_begin = wr_ctrl && reg_wdata[B_BEGIN] && !poff && !begin_q &&
                     (auto_mode ? (state == SEQ_OFF) : (state == SEQ_READY));
  assign acc_abort = wr_ctrl && reg_wdata[B_ABORT] && begin_q && !abort_q &&
                     (state == SEQ_CONVERT);
  assign auto_unlocked = (state == SEQ_OFF) && !pon && !begin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pon       <= 1'b0;
      poff      <= 1'b0;
      begin_q   <= 1'b0;
      abort_q   <= 1'b0;
      rdy_flag  <= 1'b0;
      irq_en    <= 1'b0;
      auto_mode <= 1'b0;
    end else begin
      if (off_evt) begin
        pon  <= 1'b0;
        poff <= 1'b0;
      end else begin
        if (acc_pon)  pon  <= 1'b1;
        if (acc_poff) poff <= 1'b1;
      end
      if (conv_end) begin
        begin_q <= 1'b0;
        abort_q <= 1'b0;
      end else begin
        if (acc_begin) begin_q <= 1'b1;
        if (acc_abort) abort_q <= 1'b1;
      end
      if (rdy_evt)                         rdy_flag <= 1'b1;
      else if (wr_stat && reg_wdata[0])    rdy_flag <= 1'b0;
      if (wr_cfg) begin
        irq_en <= reg_wdata[B_IE];
        if (auto_unlocked) auto_mode <= reg_wdata[B_AUTO];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_PON]   = pon;
        reg_rdata[B_POFF]  = poff;
        reg_rdata[B_BEGIN] = begin_q;
        reg_rdata[B_ABORT] = abort_q;
      end
      A_STAT: reg_rdata[0] = rdy_flag;
      A_CFG: begin
        reg_rdata[B_IE]   = irq_en;
        reg_rdata[B_AUTO] = auto_mode;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_ABORT_NEEDS_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> begin_q); // R5
  AST_POFF_LEAVES_WITH_PON: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(poff) |-> !pon); // R6
  AST_AUTO_NO_PON: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode |-> !pon); // R8
  AST_READY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |=> rdy_flag); // R3
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_seq_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       conv_done,
  input  logic       stop_ack,
  output logic       pwr_up,
  output logic       conv_req,
  output logic       rdy_irq
);
  seq_state_t state;
  logic settle_run, settle_done, rdy_evt, off_evt, conv_end;
  logic pon, poff, begin_q, abort_q, rdy_flag, irq_en, auto_mode;

  adc_seq_settle_timer #(.CYC(STARTUP_CYC)) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (settle_run),
    .done (settle_done)
  );

  adc_seq_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_mode  (auto_mode),
    .pon        (pon),
    .poff       (poff),
    .begin_q    (begin_q),
    .abort_q    (abort_q),
    .conv_done  (conv_done),
    .stop_ack   (stop_ack),
    .settle_done(settle_done),
    .state      (state),
    .settle_run (settle_run),
    .rdy_evt    (rdy_evt),
    .off_evt    (off_evt),
    .conv_end   (conv_end)
  );

  adc_seq_regs regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .state    (state),
    .rdy_evt  (rdy_evt),
    .off_evt  (off_evt),
    .conv_end (conv_end),
    .pon      (pon),
    .poff     (poff),
    .begin_q  (begin_q),
    .abort_q  (abort_q),
    .rdy_flag (rdy_flag),
    .irq_en   (irq_en),
    .auto_mode(auto_mode)
  );

  assign pwr_up   = (state != SEQ_OFF);
  assign conv_req = (state == SEQ_CONVERT) && !abort_q;
  assign rdy_irq  = rdy_flag && irq_en;

  AST_REQ_CLEARS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && !conv_end) |=> !conv_req); // R5
endmodule

// File: tb/adc_pwr_seq_tb_top.sv
module adc_pwr_seq_tb_top;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       conv_done = 1'b0;
  logic       stop_ack = 1'b0;
  logic       pwr_up, conv_req, rdy_irq;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_pwr_seq #(.STARTUP_CYC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
    .stop_ack(stop_ack), .pwr_up(pwr_up), .conv_req(conv_req), .rdy_irq(rdy_irq)
  );

  // {wr, addr, wdata, done, ack, exp_pwr, exp_req, exp_ctrl}
  localparam logic [18:0] VEC [16] = '{
    {1'b1, 2'd0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b1, 2'd0, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0101},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0101},
    {1'b1, 2'd0, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1101},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'b1101},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0001},
    {1'b1, 2'd0, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0101},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 4'b0101},
    {1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0001},
    {1'b1, 2'd0, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 4'b0011},
    {1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0; reg_addr = 2'd0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    rd(2'd0, d); chk("R1 ctrl after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd2, d); chk("R1 config after reset", d, 8'h00);
    chk("R1 outputs after reset", {5'd0, pwr_up, conv_req, rdy_irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // Vector table: R2 R4 R5 R6 in manual power mode
    for (int i = 0; i < 16; i++) begin
      reg_wr    = VEC[i][18];
      reg_addr  = VEC[i][17:16];
      reg_wdata = VEC[i][15:8];
      conv_done = VEC[i][7];
      stop_ack  = VEC[i][6];
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 8'd0; conv_done = 1'b0; stop_ack = 1'b0;
      rd(2'd0, d);
      chk($sformatf("R2 R4 R5 R6 vector %0d pwr/req/ctrl", i),
          {2'd0, pwr_up, conv_req, d[3:0]},
          {2'd0, VEC[i][5], VEC[i][4], VEC[i][3:0]});
    end

    // R3 sticky flag, write-one-to-clear, interrupt gating
    rd(2'd1, d); chk("R3 flag set by earlier power-up", d, 8'h01);
    chk("R3 irq masked", {7'd0, rdy_irq}, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R3 writing 0 keeps flag", d, 8'h01);
    wr(2'd2, 8'h01);
    chk("R3 irq enabled", {7'd0, rdy_irq}, 8'h01);
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R3 flag cleared", d, 8'h00);
    chk("R3 irq after clear", {7'd0, rdy_irq}, 8'h00);

    // R7 begin while powered down is ignored
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R7 begin ignored while off", d, 8'h00);

    // R2 exact settle timing
    wr(2'd0, 8'h01);
    chk("R2 pwr_up not yet on write edge", {7'd0, pwr_up}, 8'h00);
    idle(1);
    chk("R2 pwr_up one cycle later", {7'd0, pwr_up}, 8'h01);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R7 begin ignored while settling", d, 8'h01);
    idle(N - 2);
    rd(2'd1, d); chk("R2 flag not early", d, 8'h00);
    idle(1);
    rd(2'd1, d); chk("R2 flag after settle time", d, 8'h01);

    // R5 abort ignored with no conversion; R9 auto bit locked while powered
    wr(2'd0, 8'h08);
    rd(2'd0, d); chk("R5 abort ignored in ready", d, 8'h01);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R9 auto bit locked while on", d, 8'h01);

    // R6 power-off ignored during conversion
    wr(2'd0, 8'h04);
    idle(1);
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R6 power-off ignored while converting", d, 8'h05);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    #1;

    // R7 power-on landing in the power-off cycle is ignored
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R6 power-off pending", d, 8'h03);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R7 power-on ignored while power-off pending", d, 8'h00);
    chk("R7 pwr_up low", {7'd0, pwr_up}, 8'h00);
    idle(2);
    chk("R7 stays off", {7'd0, pwr_up}, 8'h00);

    // R8 automatic power mode, R9 auto bit writable when off
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R9 auto bit set while off", d, 8'h02);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    rd(2'd0, d); chk("R8 power-on ignored in auto", d, 8'h00);
    idle(1);
    chk("R8 pwr_up stays low", {7'd0, pwr_up}, 8'h00);
    wr(2'd0, 8'h04);
    rd(2'd0, d); chk("R8 begin accepted while off", d, 8'h04);
    idle(1);
    chk("R8 power and request", {6'd0, pwr_up, conv_req}, 8'h02);
    idle(N - 1);
    rd(2'd1, d); chk("R8 flag not early", {d[0], conv_req}, 2'b00);
    idle(1);
    rd(2'd1, d); chk("R8 flag and request after settle", {d[0], conv_req}, 2'b11);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    #1;
    rd(2'd0, d);
    chk("R8 powered down after conversion", {3'd0, pwr_up, d[3:0]}, 8'h00);

    // R10 unused address
    rd(2'd3, d); chk("R10 address 3 reads zero", d, 8'h00);

    summary();
  end
endmodule